// File: doc/BRIEF.md
# Console command completion watchdog

This block drives one command through a CPU console port and waits for the port to report that the command has finished. A caller starts it with a start pulse. The caller also supplies a mode, an optional expected read value with a don't-care mask, and flags that say whether a command error or a memory error is expected.

- In ordinary and step modes the block raises a single-cycle request.
- In run-to-halt mode no request is raised; the block only waits for the CPU to stop.
- While waiting, the block counts cycles and watches a registered copy of the port's status lines. It stops when the completion condition for the mode holds or when that mode's cycle limit is reached.

At the end the block reports a result code and the elapsed cycle count. If the limit runs out, it issues a one-cycle reset request to the surrounding system. It then refuses new commands for a fixed holdoff period. Each mode's limit can be reloaded between commands, so test sequences can tighten or relax the watchdog.

Top module: `console_cmd_watchdog`

## Requirements
- R1: A start pulse is accepted only while `ready` is high. In ordinary (`mode`=0, and also `mode`=3) and step (`mode`=1) modes, `req` is high for exactly the one cycle after the accepting edge. In run-to-halt mode (`mode`=2), `req` stays low.
- R2: In ordinary mode the command completes once `st_ack` has been seen high.
- R3: In step mode the command completes only when `st_busy` and `st_step` are both low. `st_busy` low alone is not enough.
- R4: In run-to-halt mode the command completes only when `st_busy` and `st_go` are both low.
- R5: Elapsed-count timing:
  - The request cycle counts as cycle 1, and status inputs are registered once.
  - A completion condition that first holds on the inputs during cycle c (c ≥ 1) gives `elapsed` = c+1.
  - Completion detected on the limit cycle wins over timeout.
- R6: The cycle limits reset to 50 (ordinary), 100 (step) and 5000 (run-to-halt). When `tmo_load` is high, `tmo_value` is written into the limit chosen by `tmo_sel` (0 ordinary, 1 step, 2 run). The new limit applies from the next accepted command.
- R7: With no error flag seen or expected:
  - If the check is off, the result is 1.
  - If the check is on, the result is 2 when `((dout ^ chk_data) & ~chk_mask)` is zero, and 3 otherwise. Mask bits set to 1 are ignored.
- R8: Command-error handling:
  - When `st_cmderr` is seen at completion or `exp_cmderr` is set, the result is decided by the command error alone.
  - The codes are 4 (expected and seen), 5 (seen, not expected) and 6 (expected, missed).
  - This overrides the memory-error and data outcomes.
- R9: The memory error is treated in the same way, with lower priority than the command error. The codes are 7 (expected and seen), 8 (seen, not expected) and 9 (expected, missed). It overrides the data outcome.
- R10: Timeout handling:
  - When the count reaches the limit without completion, the result is 10 and `elapsed` equals the limit.
  - `sys_reset` is high for one cycle, in the same cycle as `done`.
  - `ready` stays low for that cycle plus 9 more, and a start pulse in that window is ignored.
- R11: `done` is a one-cycle pulse. While it is high, `result` is nonzero. `result` and `elapsed` hold until the next accepted start, which clears both to 0 during the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command |
| mode | input | 2 | 0 ordinary, 1 step, 2 run-to-halt, 3 as ordinary |
| chk_en | input | 1 | Compare read data at completion |
| chk_data | input | DW | Expected read data |
| chk_mask | input | DW | Don't-care mask, 1 = ignore bit |
| exp_cmderr | input | 1 | A command error is expected |
| exp_memerr | input | 1 | A memory error is expected |
| tmo_load | input | 1 | Write a cycle limit |
| tmo_sel | input | 2 | Limit to write: 0 ordinary, 1 step, 2 run |
| tmo_value | input | CW | New limit value |
| st_ack | input | 1 | Port command acknowledge |
| st_busy | input | 1 | Port command busy |
| st_cmderr | input | 1 | Port command error |
| st_memerr | input | 1 | Port memory error |
| st_go | input | 1 | CPU running |
| st_step | input | 1 | CPU stepping |
| dout | input | DW | Port read data |
| req | output | 1 | Command request pulse |
| ready | output | 1 | New command may be started |
| done | output | 1 | Result valid pulse |
| result | output | 4 | Result code (see R7 to R10) |
| elapsed | output | CW | Cycles counted for the last command |
| sys_reset | output | 1 | Reset request on timeout |

## Verification
Ordinary commands are run with an exact read match, a match that differs only in masked bits, and a mismatch outside the mask. Together these separate the mask polarity from a plain compare. Error flags are raised alone, together, and against expectations both set and clear, which tells the command-error codes from the memory-error codes and exposes a wrong priority between them. Step and run-to-halt commands first drop only `st_busy` and later the mode's own flag, so an incomplete completion condition shows up as a short `elapsed`. Responses one cycle before and exactly at a reloaded limit, plus silent commands at each default limit, pin down the boundary between completion and timeout.

// File: rtl/console_cmd_watchdog.sv
module console_cmd_watchdog #(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int TMO_ORD  = 50,
  parameter int TMO_STEP = 100,
  parameter int TMO_RUN  = 5000,
  parameter int HOLDOFF  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          chk_en,
  input  logic [DW-1:0] chk_data,
  input  logic [DW-1:0] chk_mask,
  input  logic          exp_cmderr,
  input  logic          exp_memerr,
  input  logic          tmo_load,
  input  logic [1:0]    tmo_sel,
  input  logic [CW-1:0] tmo_value,
  input  logic          st_ack,
  input  logic          st_busy,
  input  logic          st_cmderr,
  input  logic          st_memerr,
  input  logic          st_go,
  input  logic          st_step,
  input  logic [DW-1:0] dout,
  output logic          req,
  output logic          ready,
  output logic          done,
  output logic [3:0]    result,
  output logic [CW-1:0] elapsed,
  output logic          sys_reset
);
  localparam int HW = $clog2(HOLDOFF + 1);
  localparam logic [1:0] M_STEP = 2'd1;
  localparam logic [1:0] M_RUN  = 2'd2;
  localparam logic [3:0] C_OK = 4'd1, C_DOK = 4'd2, C_DBAD = 4'd3;
  localparam logic [3:0] C_CSEEN = 4'd4, C_CUNEXP = 4'd5, C_CMISS = 4'd6;
  localparam logic [3:0] C_MSEEN = 4'd7, C_MUNEXP = 4'd8, C_MMISS = 4'd9;
  localparam logic [3:0] C_TMO = 4'd10;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RST, S_HOLD} state_t;
  state_t state;

  logic [1:0]    mode_q;
  logic          chk_q, ec_q, em_q;
  logic [DW-1:0] exp_q, mask_q;
  logic [CW-1:0] lim_q, cnt;
  logic [CW-1:0] lim_ord, lim_step, lim_run;
  logic [HW-1:0] hcnt;
  logic          ack_q, busy_q, cerr_q, merr_q, go_q, step_q;
  logic [DW-1:0] dout_q;
  logic          req_q, done_q;
  logic [3:0]    result_q;
  logic [CW-1:0] elapsed_q;

  logic          cond, hit, data_ok;
  logic [3:0]    code;

  assign req       = req_q;
  assign done      = done_q;
  assign result    = result_q;
  assign elapsed   = elapsed_q;
  assign ready     = (state == S_IDLE);
  assign sys_reset = (state == S_RST);

  assign cond = (mode_q == M_STEP) ? (!busy_q && !step_q) :
                (mode_q == M_RUN)  ? (!busy_q && !go_q)   : ack_q;
  assign hit     = cond && (cnt >= CW'(2));
  assign data_ok = ((dout_q ^ exp_q) & ~mask_q) == '0;

  always_comb begin
    if (cerr_q || ec_q)
      code = (cerr_q && ec_q) ? C_CSEEN : (cerr_q ? C_CUNEXP : C_CMISS);
    else if (merr_q || em_q)
      code = (merr_q && em_q) ? C_MSEEN : (merr_q ? C_MUNEXP : C_MMISS);
    else if (chk_q)
      code = data_ok ? C_DOK : C_DBAD;
    else
      code = C_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ack_q, busy_q, cerr_q, merr_q, go_q, step_q} <= '0;
      dout_q <= '0;
    end else begin
      {ack_q, busy_q, cerr_q, merr_q, go_q, step_q} <=
        {st_ack, st_busy, st_cmderr, st_memerr, st_go, st_step};
      dout_q <= dout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_ord  <= CW'(TMO_ORD);
      lim_step <= CW'(TMO_STEP);
      lim_run  <= CW'(TMO_RUN);
    end else if (tmo_load) begin
      case (tmo_sel)
        2'd0:    lim_ord  <= tmo_value;
        2'd1:    lim_step <= tmo_value;
        2'd2:    lim_run  <= tmo_value;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      mode_q    <= '0;
      chk_q     <= 1'b0;
      ec_q      <= 1'b0;
      em_q      <= 1'b0;
      exp_q     <= '0;
      mask_q    <= '0;
      lim_q     <= '0;
      cnt       <= '0;
      hcnt      <= '0;
      req_q     <= 1'b0;
      done_q    <= 1'b0;
      result_q  <= '0;
      elapsed_q <= '0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mode_q    <= mode;
          chk_q     <= chk_en;
          exp_q     <= chk_data;
          mask_q    <= chk_mask;
          ec_q      <= exp_cmderr;
          em_q      <= exp_memerr;
          lim_q     <= (mode == M_STEP) ? lim_step :
                       (mode == M_RUN)  ? lim_run  : lim_ord;
          cnt       <= CW'(1);
          req_q     <= (mode != M_RUN);
          result_q  <= '0;
          elapsed_q <= '0;
          state     <= S_WAIT;
        end
        S_WAIT: begin
          if (hit) begin
            done_q    <= 1'b1;
            result_q  <= code;
            elapsed_q <= cnt;
            state     <= S_IDLE;
          end else if (cnt >= lim_q) begin
            done_q    <= 1'b1;
            result_q  <= C_TMO;
            elapsed_q <= cnt;
            state     <= S_RST;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_RST: begin
          hcnt  <= HW'(HOLDOFF - 1);
          state <= S_HOLD;
        end
        default: begin
          if (hcnt == '0) state <= S_IDLE;
          else            hcnt  <= hcnt - HW'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/console_cmd_watchdog_chk.sv
module console_cmd_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] mode,
  input logic       req,
  input logic       ready,
  input logic       done,
  input logic [3:0] result,
  input logic       sys_reset
);
  assert_req_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  assert_req_issued_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready && mode != 2'd2) |=> req);
  assert_run_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready && mode == 2'd2) |=> !req);
  assert_busy_while_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !ready);
  assert_tmo_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 4'd10) |-> sys_reset);
  assert_reset_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |=> (!sys_reset && !ready));
  assert_done_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result != 4'd0);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && ready) |=> ($stable(result) || done));
endmodule

bind console_cmd_watchdog console_cmd_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .req(req),
  .ready(ready), .done(done), .result(result), .sys_reset(sys_reset)
);

// File: tb/console_cmd_watchdog_bench.sv
`timescale 1ns/1ps
module console_cmd_watchdog_bench;
  logic        clk = 0, rst_n = 0;
  logic        start = 0, chk_en = 0, exp_cmderr = 0, exp_memerr = 0;
  logic [1:0]  mode = 0, tmo_sel = 0;
  logic [15:0] chk_data = 0, chk_mask = 0, tmo_value = 0, dout = 0;
  logic        tmo_load = 0;
  logic        st_ack = 0, st_busy = 1, st_cmderr = 0, st_memerr = 0;
  logic        st_go = 1, st_step = 1;
  logic        req, ready, done, sys_reset;
  logic [3:0]  result;
  logic [15:0] elapsed;

  int checks = 0, fails = 0, done_cnt = 0, hcount = 0;
  int         q_code[$], q_el[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  console_cmd_watchdog u_console_cmd_watchdog (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .chk_en(chk_en),
    .chk_data(chk_data), .chk_mask(chk_mask), .exp_cmderr(exp_cmderr),
    .exp_memerr(exp_memerr), .tmo_load(tmo_load), .tmo_sel(tmo_sel),
    .tmo_value(tmo_value), .st_ack(st_ack), .st_busy(st_busy),
    .st_cmderr(st_cmderr), .st_memerr(st_memerr), .st_go(st_go),
    .st_step(st_step), .dout(dout), .req(req), .ready(ready), .done(done),
    .result(result), .elapsed(elapsed), .sys_reset(sys_reset));

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: samples mid-cycle, pops scoreboard on done
  always begin
    @(posedge clk); #5;
    if (rst_n) begin
      if (done) begin
        done_cnt++;
        if (q_code.size() == 0) check(0, "R11", "unexpected done", 1, 0);
        else begin
          int ec, ee; string tg;
          ec = q_code.pop_front(); ee = q_el.pop_front(); tg = q_tag.pop_front();
          check(result == ec, tg, "result code", result, ec);
          check(elapsed == ee, tg, "elapsed", elapsed, ee);
          check(sys_reset == (ec == 10), "R10", "sys_reset with done", sys_reset, ec == 10);
        end
      end
      if (sys_reset) begin
        if (hcount != 0) check(0, "R10", "sys_reset longer than one cycle", hcount, 0);
        hcount = 1;
      end else if (hcount > 0) begin
        if (!ready) hcount++;
        else begin
          check(hcount == 10, "R10", "ready-low cycles after timeout", hcount, 10);
          hcount = 0;
        end
      end
    end
  end

  initial begin
    #2_000_000;
    check(0, "R10", "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic baseline();
    st_ack = 0; st_busy = 1; st_go = 1; st_step = 1;
    st_cmderr = 0; st_memerr = 0; dout = 0;
  endtask

  task automatic load_tmo(input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk); tmo_load = 1; tmo_sel = sel; tmo_value = v;
    @(negedge clk); tmo_load = 0;
  endtask

  // c: cycle with full response (0 = none); b: cycle where only busy drops
  task automatic run_cmd(input logic [1:0] m, input int c, input int b,
                         input logic [15:0] d, input logic ce, input logic me,
                         input logic ck, input logic [15:0] ed, input logic [15:0] mk,
                         input logic xe, input logic xm,
                         input int ecode, input int eel, input string tg);
    int d0, k, w;
    w = 0;
    while (!ready && w < 100) begin @(negedge clk); w++; end
    q_code.push_back(ecode); q_el.push_back(eel); q_tag.push_back(tg);
    d0 = done_cnt;
    start = 1; mode = m; chk_en = ck; chk_data = ed; chk_mask = mk;
    exp_cmderr = xe; exp_memerr = xm;
    @(negedge clk);
    start = 0;
    check(req == (m != 2'd2), "R1", "req in request cycle", req, m != 2'd2);
    check(result == 0 && elapsed == 0, "R11", "cleared on start", result, 0);
    k = 1;
    while (done_cnt == d0 && k < 7000) begin
      if (k == b) st_busy = 0;
      if (k == c) begin
        if (m == 2'd1) begin st_busy = 0; st_step = 0; end
        else if (m == 2'd2) begin st_busy = 0; st_go = 0; end
        else st_ack = 1;
        dout = d; st_cmderr = ce; st_memerr = me;
      end
      if (k == c + 1) st_ack = 0;
      @(negedge clk);
      k++;
      if (k == 2) check(!req, "R1", "req one cycle", req, 0);
    end
    baseline();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ready && !req && !done && !sys_reset && result == 0, "R11",
          "reset state", {ready, req, done, sys_reset}, 4'b1000);
    rst_n = 1;
    @(negedge clk);

    run_cmd(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, "R2");
    repeat (5) @(negedge clk);
    check(result == 1 && elapsed == 2, "R11", "result held", result, 1);
    run_cmd(3, 3, 0, 16'h1234, 0, 0, 1, 16'h1234, 0, 0, 0, 2, 4, "R5");
    run_cmd(0, 2, 0, 16'h12F4, 0, 0, 1, 16'h1204, 16'h00F0, 0, 0, 2, 3, "R7");
    run_cmd(0, 2, 0, 16'h1305, 0, 0, 1, 16'h1204, 16'h00F0, 0, 0, 3, 3, "R7");
    run_cmd(0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3, "R7");
    run_cmd(0, 1, 0, 16'h5, 1, 0, 1, 16'h5, 0, 0, 0, 5, 2, "R8");
    run_cmd(0, 1, 0, 16'h5, 1, 0, 1, 16'h6, 0, 1, 0, 4, 2, "R8");
    run_cmd(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 6, 2, "R8");
    run_cmd(0, 1, 0, 0, 1, 1, 0, 0, 0, 0, 1, 5, 2, "R8");
    run_cmd(0, 1, 0, 0, 0, 1, 1, 16'h9, 0, 0, 0, 8, 2, "R9");
    run_cmd(0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 1, 7, 2, "R9");
    run_cmd(0, 1, 0, 0, 0, 0, 1, 16'h1, 0, 0, 1, 9, 2, "R9");
    run_cmd(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3, "R3");
    run_cmd(1, 4, 2, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5, "R3");
    run_cmd(2, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5, "R4");
    run_cmd(2, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4, "R4");

    run_cmd(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 10, 50, "R6");
    start = 1; mode = 0;
    @(negedge clk); start = 0;
    check(!req && !ready, "R10", "start ignored in holdoff", req, 0);
    run_cmd(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 10, 100, "R6");
    run_cmd(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 10, 5000, "R6");

    while (!ready) @(negedge clk);
    load_tmo(2'd0, 16'd6);
    run_cmd(0, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6, "R5");
    run_cmd(0, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 10, 6, "R10");
    while (!ready) @(negedge clk);
    load_tmo(2'd1, 16'd3);
    run_cmd(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 10, 3, "R6");

    repeat (15) @(negedge clk);
    check(q_code.size() == 0, "R11", "scoreboard drained", q_code.size(), 0);
    finish_run();
  end
endmodule